// File: doc/BRIEF.md
# Backplane SPI Controller with Shift-Register Device Select

This block drives a serial peripheral bus toward seven plug-in slots of an instrument backplane. Each slot has a private active-low module-select line. Behind that line the module carries one or more chained 8-bit serial-in/parallel-out registers whose latched outputs act as the chip selects of the devices on that module. A single command names the slot, the device behind the register chain, a byte count and the bytes to send.

A transaction has two clock regimes. First, with the module selected, a one-hot, active-low select word is shifted into the on-module register chain at a fast serial clock and latched. This pulls exactly one device select low. Second, the data bytes are exchanged at that slot's own, usually slower, serial clock in mode 0. When the data bytes are done, an all-ones word is shifted and latched to deselect the device. The module select is then released and the received bytes are returned with a one-cycle done pulse.

Both serial clock rates are half-period counts of the system clock. One count sets the rate of the select word. Seven counts, one per slot, set the data rate, so the nearer slots can run faster than the rest.

Top module: `spi_slot_ctrl`

## Requirements
- R1: After reset and whenever no transaction runs, every bit of msel_n is 1, sclk is 0, latch is 0 and busy is 0.
- R2: During an accepted transaction, only msel_n[slot-1] is 0, where slot is the value of cmd_slot (1 to 7). It stays 0 from the start of the select word until the deselect word has been latched.
- R3: The select word is PW = 8*CHAIN bits, sent MSB first and valid on each rising sclk edge. Every bit is 1 except bit number cmd_dev, which is 0.
- R4: After the last select-word bit, latch is driven high for one fast half-period while sclk is low. The same happens after the deselect word.
- R5: Each sclk half-period lasts fast_half+1 system clocks while a select or deselect word is shifted. It lasts slot_half[slot-1]+1 system clocks during the data bytes.
- R6: Data uses SPI mode 0 and is sent MSB first. The first byte sent is cmd_wdata[7:0], then cmd_wdata[15:8], and so on. miso is sampled on rising sclk edges, and the k-th received byte appears at rdata[8k+7:8k].
- R7: After the data bytes, an all-ones word of PW bits is shifted and latched, the module select is released, and done pulses for one cycle with rdata valid.
- R8: A command is rejected if cmd_slot is 0, if cmd_dev is PW or more, or if cmd_len is 0 or more than MAXB. A rejected command gives err high for one cycle and moves no output pin.
- R9: cmd_valid is ignored while busy is 1. It neither alters the running transaction nor starts another.
- R10: mosi does not change while sclk is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_slot | input | 3 | Target slot, 1 to 7 |
| cmd_dev | input | 5 | Device index within the register chain |
| cmd_len | input | LW | Number of data bytes, 1 to MAXB |
| cmd_wdata | input | 8*MAXB | Bytes to send, byte 0 first |
| fast_half | input | DW | Half-period count for select words |
| slot_half | input | 7*DW | Per-slot half-period counts for data, slot s at index s-1 |
| miso | input | 1 | Serial data from the slot |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | One-cycle rejected-command pulse |
| rdata | output | 8*MAXB | Received bytes |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slot |
| latch | output | 1 | Register-chain output latch strobe |
| msel_n | output | 7 | Active-low module selects, bit s-1 for slot s |

## Verification
The bench builds the block with CHAIN=2 and MAXB=4. The 16-bit select word therefore spans two chained registers, so device indices 8 to 15 reach the second register and index 16 is the first one rejected. A four-byte limit allows single-byte, full-length and over-length commands. Random half-period counts from 0 to 5 include the divide-by-one case, where the select clock toggles every system clock, alongside data clocks both faster and slower than it.

// File: rtl/spi_slot_ctrl.sv
module spi_slot_ctrl #(
  parameter int CHAIN = 1,
  parameter int MAXB = 4,
  parameter int DW = 8,
  localparam int PW = 8 * CHAIN,
  localparam int LW = $clog2(MAXB + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_slot,
  input  logic [4:0]           cmd_dev,
  input  logic [LW-1:0]        cmd_len,
  input  logic [8*MAXB-1:0]    cmd_wdata,
  input  logic [DW-1:0]        fast_half,
  input  logic [6:0][DW-1:0]   slot_half,
  input  logic                 miso,
  output logic                 busy,
  output logic                 done,
  output logic                 err,
  output logic [8*MAXB-1:0]    rdata,
  output logic                 sclk,
  output logic                 mosi,
  output logic                 latch,
  output logic [6:0]           msel_n
);
  localparam int CW = $clog2(PW);
  localparam int BW = (MAXB > 1) ? $clog2(MAXB) : 1;

  typedef enum logic [2:0] {IDLE, SEL, LAT, DAT, DES, LAT2} st_t;
  st_t st;

  logic [DW-1:0]     cnt;
  logic              ph, rb;
  logic [CW-1:0]     bits;
  logic [2:0]        slot_r;
  logic [LW-1:0]     len_r;
  logic [BW-1:0]     byten;
  logic [PW-1:0]     sreg;
  logic [7:0]        dreg;
  logic [8*MAXB-1:0] wbuf, wnext;

  wire shifting = (st == SEL) || (st == DAT) || (st == DES);
  wire [DW-1:0] hsel = (st == DAT) ? slot_half[slot_r - 3'd1] : fast_half;
  wire tick = (cnt == hsel);
  wire bad = (cmd_slot == 3'd0) || (32'(cmd_dev) >= PW) ||
             (cmd_len == '0) || (32'(cmd_len) > MAXB);
  wire last_sel = (32'(bits) == PW - 1);
  wire [7:0] rx_byte = {dreg[6:0], rb};

  assign wnext = wbuf >> 8;
  assign busy  = (st != IDLE);
  assign sclk  = shifting && ph;
  assign latch = (st == LAT) || (st == LAT2);
  assign mosi  = (st == DAT) ? dreg[7] : ((st == SEL || st == DES) ? sreg[PW-1] : 1'b0);

  for (genvar i = 0; i < 7; i++) begin : g_sel
    assign msel_n[i] = !(busy && slot_r == 3'(i + 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; ph <= 1'b0; rb <= 1'b0; bits <= '0;
      slot_r <= '0; len_r <= '0; byten <= '0; sreg <= '1; dreg <= '0;
      wbuf <= '0; rdata <= '0; done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (st == IDLE) begin
        if (cmd_valid) begin
          if (bad) err <= 1'b1;
          else begin
            st <= SEL; cnt <= '0; ph <= 1'b0; bits <= '0; byten <= '0;
            slot_r <= cmd_slot; len_r <= cmd_len; wbuf <= cmd_wdata;
            dreg <= cmd_wdata[7:0]; rdata <= '0;
            sreg <= ~(PW'(1) << cmd_dev);
          end
        end
      end else if (!tick) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        if (shifting && !ph) begin
          ph <= 1'b1;
          if (st == DAT) rb <= miso;
        end else begin
          ph <= 1'b0;
          unique case (st)
            SEL, DES: begin
              sreg <= sreg << 1;
              bits <= bits + 1'b1;
              if (last_sel) st <= (st == SEL) ? LAT : LAT2;
            end
            LAT: begin
              st <= DAT; bits <= '0;
            end
            DAT: begin
              dreg <= rx_byte;
              bits <= bits + 1'b1;
              if (bits[2:0] == 3'd7) begin
                rdata[byten*8 +: 8] <= rx_byte;
                bits <= '0;
                if (32'(byten) == 32'(len_r) - 1) begin
                  st <= DES; sreg <= '1;
                end else begin
                  byten <= byten + 1'b1;
                  wbuf  <= wnext;
                  dreg  <= wnext[7:0];
                end
              end
            end
            LAT2: begin
              st <= IDLE; done <= 1'b1;
            end
            default: st <= IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/spi_slot_ctrl_chk.sv
module spi_slot_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk,
  input logic       mosi,
  input logic       latch,
  input logic [6:0] msel_n,
  input logic       busy,
  input logic       done,
  input logic       err
);
  assert_one_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~msel_n));

  assert_select_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&msel_n) && !done) |=> (&msel_n) || $stable(msel_n));

  assert_latch_low_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    latch |-> !sclk);

  assert_quiet_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (&msel_n) |-> (!sclk && !latch));

  assert_reject_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ((&msel_n) && !busy && !sclk));

  assert_release_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (&msel_n));

  assert_mosi_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

bind spi_slot_ctrl spi_slot_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .latch(latch),
  .msel_n(msel_n), .busy(busy), .done(done), .err(err)
);

// File: tb/sim_spi_slot_ctrl.sv
`timescale 1ns/1ps
module sim_spi_slot_ctrl;
  localparam int CHAIN = 2, MAXB = 4, DW = 8, PW = 8 * CHAIN, LW = $clog2(MAXB + 1);

  logic clk = 0, rst_n = 0, cmd_valid = 0, miso;
  logic [2:0] cmd_slot = 0;
  logic [4:0] cmd_dev = 0;
  logic [LW-1:0] cmd_len = 0;
  logic [8*MAXB-1:0] cmd_wdata = 0, rdata;
  logic [DW-1:0] fast_half = 0;
  logic [6:0][DW-1:0] slot_half = '0;
  logic busy, done, err, sclk, mosi, latch;
  logic [6:0] msel_n;

  always #10 clk = ~clk;

  spi_slot_ctrl #(.CHAIN(CHAIN), .MAXB(MAXB), .DW(DW)) u0 (.*);

  int total = 0, bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // module-side model: register chain and one device
  logic [PW-1:0] lat_sh = '1, lat_q = '1, lat_first = '1;
  logic [31:0] sl_sh = 0, spat = 0;
  int tslot = 1, tdev = 0, ncap = 0, nlat = 0;
  logic cap [0:255];
  logic cs_n;
  int t_r = 0, hi_fast = 0, hi_data = 0;
  bit want_fast = 0, want_data = 0;
  logic [6:0] msel_at_lat = '1;

  assign cs_n = msel_n[tslot-1] | lat_q[tdev];
  assign miso = sl_sh[31];

  always @(posedge sclk) begin
    lat_sh <= {lat_sh[PW-2:0], mosi};
    t_r = cyc;
    if (!cs_n && ncap < 256) begin cap[ncap] = mosi; ncap++; end
  end
  always @(negedge sclk) begin
    if (want_fast) begin hi_fast = cyc - t_r; want_fast = 0; end
    else if (want_data && !cs_n) begin hi_data = cyc - t_r; want_data = 0; end
    if (!cs_n) sl_sh <= sl_sh << 1;
  end
  always @(posedge latch) begin
    lat_q <= lat_sh;
    if (nlat == 0) begin lat_first <= lat_sh; msel_at_lat <= msel_n; end
    nlat++;
  end
  always @(negedge cs_n) begin sl_sh <= spat; want_data = 1; end
  always @(negedge (&msel_n)) want_fast = 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] sel_word(input int d);
    return ~(PW'(1) << d);
  endfunction

  function automatic logic [7:0] exp_rx(input logic [31:0] p, input int k);
    return p[31-8*k -: 8];
  endfunction

  task automatic issue(input int s, input int d, input int l, input logic [8*MAXB-1:0] w);
    @(negedge clk);
    cmd_slot = 3'(s); cmd_dev = 5'(d); cmd_len = LW'(l); cmd_wdata = w; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic run(input int s, input int d, input int l, input logic [8*MAXB-1:0] w,
                     input logic [31:0] p, input bit poke);
    int n;
    tslot = s; tdev = d; spat = p; ncap = 0; nlat = 0;
    hi_fast = -1; hi_data = -1;
    issue(s, d, l, w);
    chk(busy === 1'b1, "R2 busy after accept", busy, 1);
    chk(msel_n === ~(7'(1) << (s - 1)), "R2 select line", msel_n, ~(7'(1) << (s - 1)));
    if (poke) begin
      // R9: another command while busy
      cmd_slot = 3'(s == 7 ? 1 : s + 1); cmd_dev = 0; cmd_len = 1; cmd_wdata = '1; cmd_valid = 1;
      @(negedge clk); cmd_valid = 0;
    end
    n = 0;
    while (done !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
    chk(n < 20000, "R7 done reached", n, 0);
    chk(lat_first === sel_word(d), "R3 select word", lat_first, sel_word(d));
    chk(msel_at_lat === ~(7'(1) << (s - 1)), "R2 select held at latch", msel_at_lat, ~(7'(1) << (s - 1)));
    chk(nlat == 2, "R4 latch pulses", nlat, 2);
    chk(lat_q === '1, "R7 deselect word", lat_q, '1);
    chk(msel_n === 7'h7f, "R7 select released", msel_n, 7'h7f);
    chk(hi_fast == int'(fast_half) + 1, "R5 select clock half", hi_fast, int'(fast_half) + 1);
    chk(hi_data == int'(slot_half[s-1]) + 1, "R5 data clock half", hi_data, int'(slot_half[s-1]) + 1);
    for (int k = 0; k < l; k++) begin
      logic [7:0] got;
      got = '0;
      for (int b = 0; b < 8; b++) got = {got[6:0], cap[8*k+b]};
      chk(got === w[8*k +: 8], "R6 sent byte", got, w[8*k +: 8]);
      chk(rdata[8*k +: 8] === exp_rx(p, k), "R6 received byte", rdata[8*k +: 8], exp_rx(p, k));
    end
    if (poke) begin
      repeat (20) @(negedge clk);
      chk(busy === 1'b0 && msel_n === 7'h7f, "R9 no second transaction", busy, 0);
    end
  endtask

  task automatic reject(input int s, input int d, input int l);
    issue(s, d, l, 32'hA5A5A5A5);
    chk(err === 1'b1, "R8 err pulse", err, 1);
    for (int i = 0; i < 6; i++) begin
      chk(msel_n === 7'h7f && sclk === 1'b0 && latch === 1'b0 && busy === 1'b0,
          "R8 pins untouched", {msel_n, sclk, latch, busy}, {7'h7f, 3'b000});
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(msel_n === 7'h7f && sclk === 0 && latch === 0 && busy === 0, "R1 reset pins",
        {msel_n, sclk, latch, busy}, {7'h7f, 3'b000});
    rst_n = 1;
    @(negedge clk);
    chk(msel_n === 7'h7f && sclk === 0 && busy === 0, "R1 idle pins", {msel_n, sclk, busy}, {7'h7f, 2'b00});

    // directed corners
    fast_half = 0;
    for (int i = 0; i < 7; i++) slot_half[i] = DW'(i < 2 ? 1 : 4);
    run(1, 0, 1, 32'h0000_003C, 32'hC3000000, 0);
    run(7, 15, 4, 32'h1234_5678, 32'h9ABCDEF0, 0);
    run(2, 8, 2, 32'h0000_FF00, 32'h00FF0000, 1);
    fast_half = 5;
    run(3, 7, 3, 32'h00AA_5501, 32'h80017FFE, 0);
    reject(0, 0, 1);
    reject(4, 16, 1);
    reject(4, 31, 2);
    reject(4, 3, 0);
    reject(4, 3, 5);

    // constrained random
    for (int t = 0; t < 40; t++) begin
      int s, d, l;
      fast_half = DW'($urandom_range(0, 2));
      for (int i = 0; i < 7; i++) slot_half[i] = DW'($urandom_range(0, 5));
      s = $urandom_range(1, 7);
      d = $urandom_range(0, PW - 1);
      l = $urandom_range(1, MAXB);
      run(s, d, l, {$urandom}, $urandom, (t % 8) == 3);
    end

    @(negedge clk);
    chk(msel_n === 7'h7f && busy === 0, "R1 idle at end", {msel_n, busy}, {7'h7f, 1'b0});
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule